// File: doc/BRIEF.md
# RMII Frame Receiver

This block takes the receive side of a 100 Mbit/s RMII link: a carrier/data-valid strobe and a two-bit data bus, both sampled on the 50 MHz reference clock. It waits for a run of preamble dibits followed by the start delimiter dibit, then packs the dibits that follow into bytes, least significant dibit first. The bytes leave as a stream that starts at the destination address and ends with the last byte of the frame check sequence.

Each frame gets a pass/fail verdict. The CRC-32 runs over everything from the destination address through the received check sequence, and the frame passes only if the fixed residue remains. The verdict also covers the frame length, a trailing partial byte, and whether the type/length field holds a protocol type. The verdict and the type flag appear on the same cycle as the frame's last byte. An address filter holds the first six bytes back until it knows whether the destination matches the station address. A non-matching frame produces no output at all, unless promiscuous mode is set.

Top module: `rmii_frame_rx`

## Requirements
- R1: While reset is asserted and after its release, with no carrier, `valid_o`, `last_o`, `good_o` and `type_o` are 0.
- R2: After one or more dibits of `rxd_i`=2'b01 (bit 1 is RXD1) and then one dibit of 2'b11, each following group of four dibits forms one byte, the first dibit giving bits 1:0. Bytes come out on `data_o` with `valid_o` in arrival order, starting at the first destination address byte.
- R3: `good_o` is 1 only if the CRC-32 over all received bytes, including the four check bytes, leaves the residue 0xC704DD7B. The CRC is reflected, polynomial 0x04C11DB7, initial value all ones.
- R4: The last byte of a frame, which is the last check sequence byte, is marked with `last_o`. `good_o` and `type_o` are valid only on that cycle and are 0 on every other cycle.
- R5: With `promisc_i`=0, a frame whose first six bytes differ from `station_addr_i` produces no `valid_o` at all. The first byte is compared with bits 47:40.
- R6: With `promisc_i`=1, a frame is delivered whatever its destination address.
- R7: A frame of fewer than 64 or more than 1518 bytes, counted from the destination address through the check sequence, ends with `good_o`=0. The boundary lengths 64 and 1518 are accepted.
- R8: If the carrier drops while a byte is incomplete, the completed bytes are delivered and the frame ends with `good_o`=0.
- R9: A dibit other than 2'b01 or 2'b11 during the preamble abandons the frame until the carrier drops, and nothing is output.
- R10: `type_o` is 1 on the last byte when bytes 12 and 13, high byte first, hold a value of 1536 or more, and 0 when they hold 1500 or less.
- R11: A frame that ends with fewer than six complete bytes produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz RMII reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| crs_dv_i | input | 1 | Carrier sense / receive data valid |
| rxd_i | input | 2 | Receive dibit, bit 0 is RXD0 |
| station_addr_i | input | 48 | Station address, bits 47:40 are the first byte on the wire |
| promisc_i | input | 1 | Deliver frames regardless of destination |
| data_o | output | 8 | Received byte |
| valid_o | output | 1 | `data_o` holds a byte |
| last_o | output | 1 | Final byte of the frame |
| good_o | output | 1 | Frame passed the CRC, length and alignment checks (with `last_o`) |
| type_o | output | 1 | Type/length field is a protocol type (with `last_o`) |

## Verification
The bench sends frames with correct check sequences and compares every delivered byte with the bytes sent. It repeats this with a single corrupted payload byte, which separates a residue check from a check that only passes data through. Frames of 60, 64, 1518 and 1519 bytes test each side of both length limits. Type fields of 46, 1500, 1536 and 0x0800 test both sides of the type flag. Matching and non-matching destinations with and without promiscuous mode, a trailing single dibit, a corrupted preamble and a three-byte runt each exercise one of the suppression and verdict paths.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

  typedef enum logic [1:0] {
    SYNC_IDLE,
    SYNC_PRE,
    SYNC_DATA,
    SYNC_HOLD
  } sync_state_e;

  localparam logic [1:0]  DIBIT_PRE  = 2'b01;
  localparam logic [1:0]  DIBIT_SFD  = 2'b11;
  localparam logic [1:0]  DIBIT_ZERO = 2'b00;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT      = 32'hFFFF_FFFF;
  // 0xC704DD7B as seen in a shift-right (reflected) register
  localparam logic [31:0] CRC_RESIDUE_REFL = 32'hDEBB20E3;

  function automatic logic [31:0] crc32_byte(input logic [31:0] crc, input logic [7:0] data);
    logic [31:0] c;
    c = crc ^ {24'd0, data};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/rmii_rx_align.sv
module rmii_rx_align
  import rmii_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       crs_dv_i,
  input  logic [1:0] rxd_i,
  output logic       sof_o,
  output logic [7:0] byte_o,
  output logic       byte_stb_o,
  output logic       eof_o,
  output logic       frag_o
);

  sync_state_e state_q;
  logic [1:0]  dcnt_q;
  logic [7:0]  shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SYNC_IDLE;
      dcnt_q     <= '0;
      shift_q    <= '0;
      byte_o     <= '0;
      byte_stb_o <= 1'b0;
      sof_o      <= 1'b0;
      eof_o      <= 1'b0;
      frag_o     <= 1'b0;
    end else begin
      byte_stb_o <= 1'b0;
      sof_o      <= 1'b0;
      eof_o      <= 1'b0;
      unique case (state_q)
        SYNC_IDLE: begin
          if (crs_dv_i) begin
            if (rxd_i == DIBIT_PRE)       state_q <= SYNC_PRE;
            else if (rxd_i != DIBIT_ZERO) state_q <= SYNC_HOLD;
          end
        end
        SYNC_PRE: begin
          if (!crs_dv_i) begin
            state_q <= SYNC_IDLE;
          end else if (rxd_i == DIBIT_SFD) begin
            state_q <= SYNC_DATA;
            dcnt_q  <= '0;
            sof_o   <= 1'b1;
          end else if (rxd_i != DIBIT_PRE) begin
            state_q <= SYNC_HOLD;
          end
        end
        SYNC_DATA: begin
          if (!crs_dv_i) begin
            state_q <= SYNC_IDLE;
            eof_o   <= 1'b1;
            frag_o  <= (dcnt_q != 2'd0);
          end else begin
            shift_q <= {rxd_i, shift_q[7:2]};
            dcnt_q  <= dcnt_q + 2'd1;
            if (dcnt_q == 2'd3) begin
              byte_o     <= {rxd_i, shift_q[7:2]};
              byte_stb_o <= 1'b1;
            end
          end
        end
        SYNC_HOLD: begin
          if (!crs_dv_i) state_q <= SYNC_IDLE;
        end
        default: state_q <= SYNC_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rmii_rx_crc.sv
module rmii_rx_crc
  import rmii_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       stb_i,
  input  logic [7:0] byte_i,
  output logic       ok_o
);

  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= CRC_INIT;
    else if (clear_i) crc_q <= CRC_INIT;
    else if (stb_i)   crc_q <= crc32_byte(crc_q, byte_i);
  end

  assign ok_o = (crc_q == CRC_RESIDUE_REFL);

endmodule

// File: rtl/rmii_rx_window.sv
module rmii_rx_window #(
  parameter int unsigned ADDR_BYTES = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [8*ADDR_BYTES-1:0] station_addr_i,
  input  logic                    promisc_i,
  input  logic                    sof_i,
  input  logic                    stb_i,
  input  logic [7:0]              byte_i,
  input  logic                    eof_i,
  input  logic                    good_i,
  input  logic                    type_i,
  output logic [7:0]              data_o,
  output logic                    valid_o,
  output logic                    last_o,
  output logic                    good_o,
  output logic                    type_o
);

  localparam int unsigned CW = $clog2(ADDR_BYTES + 1);
  localparam logic [CW-1:0] FULL = CW'(ADDR_BYTES);

  logic [7:0]    exp_byte [ADDR_BYTES];
  logic [7:0]    buf_q    [ADDR_BYTES];
  logic [CW-1:0] fill_q;
  logic [CW-1:0] left_q;
  logic          mismatch_q;
  logic          drain_q;
  logic          good_q;
  logic          type_q;
  logic          accept;

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_addr
    assign exp_byte[k] = station_addr_i[8*(ADDR_BYTES-1-k) +: 8];
  end

  assign accept = promisc_i | ~mismatch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < ADDR_BYTES; k++) buf_q[k] <= '0;
      fill_q     <= '0;
      left_q     <= '0;
      mismatch_q <= 1'b0;
      drain_q    <= 1'b0;
      good_q     <= 1'b0;
      type_q     <= 1'b0;
      data_o     <= '0;
      valid_o    <= 1'b0;
      last_o     <= 1'b0;
      good_o     <= 1'b0;
      type_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      good_o  <= 1'b0;
      type_o  <= 1'b0;

      if (sof_i) begin
        fill_q     <= '0;
        mismatch_q <= 1'b0;
      end else if (stb_i) begin
        if (fill_q < FULL) begin
          buf_q[fill_q] <= byte_i;
          if (byte_i != exp_byte[fill_q]) mismatch_q <= 1'b1;
          fill_q <= fill_q + 1'b1;
        end else begin
          // window full: oldest byte leaves as the new one enters
          data_o  <= buf_q[0];
          valid_o <= accept;
          for (int k = 0; k < ADDR_BYTES - 1; k++) buf_q[k] <= buf_q[k+1];
          buf_q[ADDR_BYTES-1] <= byte_i;
        end
      end else if (eof_i) begin
        fill_q <= '0;
        if (fill_q == FULL && accept) begin
          drain_q <= 1'b1;
          left_q  <= FULL;
          good_q  <= good_i;
          type_q  <= type_i;
        end
      end

      if (drain_q) begin
        data_o  <= buf_q[0];
        valid_o <= 1'b1;
        for (int k = 0; k < ADDR_BYTES - 1; k++) buf_q[k] <= buf_q[k+1];
        left_q <= left_q - 1'b1;
        if (left_q == CW'(1)) begin
          drain_q <= 1'b0;
          last_o  <= 1'b1;
          good_o  <= good_q;
          type_o  <= type_q;
        end
      end
    end
  end

endmodule

// File: rtl/rmii_frame_rx.sv
module rmii_frame_rx #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned MIN_LEN    = 64,
  parameter int unsigned MAX_LEN    = 1518,
  parameter int unsigned TYPE_MIN   = 1536
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    crs_dv_i,
  input  logic [1:0]              rxd_i,
  input  logic [8*ADDR_BYTES-1:0] station_addr_i,
  input  logic                    promisc_i,
  output logic [7:0]              data_o,
  output logic                    valid_o,
  output logic                    last_o,
  output logic                    good_o,
  output logic                    type_o
);

  localparam int unsigned CNT_W = $clog2(MAX_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ET_HI    = CNT_W'(2 * ADDR_BYTES);
  localparam logic [CNT_W-1:0] ET_LO    = CNT_W'(2 * ADDR_BYTES + 1);

  logic             sof, stb, eof, frag, crc_ok;
  logic [7:0]       rx_byte;
  logic [CNT_W-1:0] byte_cnt_q;
  logic [15:0]      etype_q;
  logic             frame_good, frame_type;

  rmii_rx_align u_align (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .crs_dv_i   (crs_dv_i),
    .rxd_i      (rxd_i),
    .sof_o      (sof),
    .byte_o     (rx_byte),
    .byte_stb_o (stb),
    .eof_o      (eof),
    .frag_o     (frag)
  );

  rmii_rx_crc u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (sof),
    .stb_i   (stb),
    .byte_i  (rx_byte),
    .ok_o    (crc_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_cnt_q <= '0;
      etype_q    <= '0;
    end else if (sof) begin
      byte_cnt_q <= '0;
      etype_q    <= '0;
    end else if (stb) begin
      if (byte_cnt_q != CNT_MAX) byte_cnt_q <= byte_cnt_q + 1'b1;
      if (byte_cnt_q == ET_HI) etype_q[15:8] <= rx_byte;
      if (byte_cnt_q == ET_LO) etype_q[7:0]  <= rx_byte;
    end
  end

  assign frame_good = crc_ok && !frag &&
                      (byte_cnt_q >= CNT_W'(MIN_LEN)) && (byte_cnt_q <= CNT_W'(MAX_LEN));
  assign frame_type = (etype_q >= 16'(TYPE_MIN));

  rmii_rx_window #(.ADDR_BYTES(ADDR_BYTES)) u_window (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .station_addr_i (station_addr_i),
    .promisc_i      (promisc_i),
    .sof_i          (sof),
    .stb_i          (stb),
    .byte_i         (rx_byte),
    .eof_i          (eof),
    .good_i         (frame_good),
    .type_i         (frame_type),
    .data_o         (data_o),
    .valid_o        (valid_o),
    .last_o         (last_o),
    .good_o         (good_o),
    .type_o         (type_o)
  );

endmodule

// File: rtl/rmii_frame_rx_chk.sv
module rmii_frame_rx_chk #(
  parameter int unsigned CNT_W   = 11,
  parameter int unsigned MIN_LEN = 64,
  parameter int unsigned MAX_LEN = 1518
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_o,
  input logic             last_o,
  input logic             good_o,
  input logic             type_o,
  input logic             crc_ok_i,
  input logic [CNT_W-1:0] byte_cnt_i
);

  always_comb begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!valid_o && !last_o && !good_o && !type_o);
    end
  end

  assert_last_has_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  assert_good_on_last_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_o |-> last_o);

  assert_type_on_last_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    type_o |-> last_o);

  // frames are separated by more than the six-cycle drain
  assert_good_residue_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_o |-> crc_ok_i);

  assert_good_length_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_o |-> (byte_cnt_i >= CNT_W'(MIN_LEN) && byte_cnt_i <= CNT_W'(MAX_LEN)));

endmodule

bind rmii_frame_rx rmii_frame_rx_chk #(
  .CNT_W   (CNT_W),
  .MIN_LEN (MIN_LEN),
  .MAX_LEN (MAX_LEN)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_o    (valid_o),
  .last_o     (last_o),
  .good_o     (good_o),
  .type_o     (type_o),
  .crc_ok_i   (crc_ok),
  .byte_cnt_i (byte_cnt_q)
);

// File: tb/rmii_frame_rx_test.sv
module rmii_frame_rx_test;

  localparam logic [47:0] STA   = 48'h02_11_22_33_44_55;
  localparam logic [47:0] OTHER = 48'h02_AA_BB_CC_DD_EE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        crs = 1'b0;
  logic [1:0]  rxd = 2'b00;
  logic        promisc = 1'b0;
  logic [7:0]  data_o;
  logic        valid_o, last_o, good_o, type_o;

  int nchk = 0;
  int nfail = 0;

  logic [7:0] fr  [0:1599];
  logic [7:0] cap [0:1599];
  int ncap, nlast, last_idx;
  logic cap_good, cap_type;
  int stray_flags;

  always #2 clk = ~clk;

  rmii_frame_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .crs_dv_i(crs), .rxd_i(rxd),
    .station_addr_i(STA), .promisc_i(promisc),
    .data_o(data_o), .valid_o(valid_o), .last_o(last_o),
    .good_o(good_o), .type_o(type_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if ((good_o || type_o) && !last_o) stray_flags++;
      if (valid_o) begin
        if (ncap < 1600) cap[ncap] = data_o;
        if (last_o) begin
          nlast++;
          last_idx = ncap;
          cap_good = good_o;
          cap_type = type_o;
        end
        ncap++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[0] ^ d[i];
      r = r >> 1;
      if (fb) r = r ^ 32'hEDB88320;
    end
    return r;
  endfunction

  task automatic build(input int len, input logic [47:0] dst, input logic [15:0] et);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) fr[i] = dst[8*(5-i) +: 8];
    for (int i = 0; i < 6; i++) fr[6+i] = 8'h40 + 8'(i);
    fr[12] = et[15:8];
    fr[13] = et[7:0];
    for (int i = 14; i < len - 4; i++) fr[i] = 8'(i * 7 + 3);
    for (int i = 0; i < len - 4; i++) c = crc_step(c, fr[i]);
    c = ~c;
    for (int i = 0; i < 4; i++) fr[len-4+i] = c[8*i +: 8];
  endtask

  task automatic send_dibit(input logic [1:0] d);
    @(negedge clk);
    crs = 1'b1;
    rxd = d;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 4; i++) send_dibit(b[2*i +: 2]);
  endtask

  task automatic send(input int len, input int extra_dibits, input bit bad_pre);
    ncap = 0; nlast = 0; last_idx = -1; cap_good = 0; cap_type = 0; stray_flags = 0;
    for (int i = 0; i < 28; i++) send_dibit((bad_pre && i == 10) ? 2'b10 : 2'b01);
    send_dibit(2'b11);
    for (int i = 0; i < len; i++) send_byte(fr[i]);
    for (int i = 0; i < extra_dibits; i++) send_dibit(2'b00);
    @(negedge clk);
    crs = 1'b0;
    rxd = 2'b00;
    repeat (40) @(negedge clk);
  endtask

  task automatic expect_frame(input int len, input bit good, input bit typ, input string req);
    int bad = 0;
    check(ncap == len, {req, " byte count"}, ncap, len);
    check(nlast == 1 && last_idx == len - 1, {req, " last position"}, last_idx, len - 1);
    for (int i = 0; i < len && i < ncap; i++) if (cap[i] !== fr[i]) bad++;
    check(bad == 0, {req, " byte mismatches"}, bad, 0);
    check(cap_good == good, {req, " good flag"}, int'(cap_good), int'(good));
    check(cap_type == typ, {req, " type flag"}, int'(cap_type), int'(typ));
    check(stray_flags == 0, {req, " R4 flags off last"}, stray_flags, 0);
  endtask

  task automatic t_reset;
    check(!valid_o && !last_o && !good_o && !type_o, "R1 reset outputs", int'(valid_o), 0);
  endtask

  task automatic t_min_good;  // R2 R3 R4 R10
    build(64, STA, 16'h0800);
    send(64, 0, 0);
    expect_frame(64, 1, 1, "R2/R3 min frame");
  endtask

  task automatic t_bad_fcs;  // R3
    build(100, STA, 16'h0800);
    fr[40] = fr[40] ^ 8'h04;
    send(100, 0, 0);
    expect_frame(100, 0, 1, "R3 corrupted byte");
  endtask

  task automatic t_filter;  // R5
    promisc = 0;
    build(80, OTHER, 16'h0806);
    send(80, 0, 0);
    check(ncap == 0, "R5 foreign address dropped", ncap, 0);
  endtask

  task automatic t_promisc;  // R6
    promisc = 1;
    build(80, OTHER, 16'h0806);
    send(80, 0, 0);
    expect_frame(80, 1, 1, "R6 promiscuous");
    promisc = 0;
  endtask

  task automatic t_lengths;  // R7
    build(60, STA, 16'h0800);   send(60, 0, 0);   expect_frame(60, 0, 1, "R7 60 bytes");
    build(1518, STA, 16'h0800); send(1518, 0, 0); expect_frame(1518, 1, 1, "R7 1518 bytes");
    build(1519, STA, 16'h0800); send(1519, 0, 0); expect_frame(1519, 0, 1, "R7 1519 bytes");
  endtask

  task automatic t_partial;  // R8
    build(70, STA, 16'h0800);
    send(70, 1, 0);
    expect_frame(70, 0, 1, "R8 trailing dibit");
  endtask

  task automatic t_bad_preamble;  // R9
    build(70, STA, 16'h0800);
    send(70, 0, 1);
    check(ncap == 0, "R9 broken preamble ignored", ncap, 0);
  endtask

  task automatic t_type_bounds;  // R10
    build(64, STA, 16'd46);   send(64, 0, 0); expect_frame(64, 1, 0, "R10 length 46");
    build(64, STA, 16'd1500); send(64, 0, 0); expect_frame(64, 1, 0, "R10 length 1500");
    build(64, STA, 16'd1536); send(64, 0, 0); expect_frame(64, 1, 1, "R10 type 1536");
  endtask

  task automatic t_runt;  // R11
    build(64, STA, 16'h0800);
    send(3, 0, 0);
    check(ncap == 0, "R11 three-byte runt", ncap, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_min_good();
    t_bad_fcs();
    t_filter();
    t_promisc();
    t_lengths();
    t_partial();
    t_bad_preamble();
    t_type_bounds();
    t_runt();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule